// File: doc/BRIEF.md
# Permutation Insertion Mutator

This block applies a shift-style mutation to one chromosome that is stored as a permutation of N element codes. Two 1-based positions are given: a source position and a target position. The element found at the source is lifted out and dropped at the target, and every element between the two slides by one place to close the gap. Because elements are only moved and never rewritten, the result is always a reordering of the input.

The caller presents the chromosome, both positions and an enable together with a one-cycle `start` pulse. The new order is formed combinationally, one output slot at a time, and is captured into an output register on that edge. `done` rises in the following cycle. Random position generation and the decision to mutate belong to the caller. A low enable, equal positions or a position outside 1..N all return the chromosome unchanged.

Top module: `perm_shift_mutator`

## Requirements
- R1: While `rst_n` is low, `chrom_out` is all zeros and `done` is 0.
- R2: `done` is high in exactly the cycle after a cycle in which `start` was high, and low in every other cycle.
- R3: `chrom_out` changes only on an edge where `start` is high. Input changes at other times leave `chrom_out` as it was.
- R4: Slot k (1-based, 1..N) occupies bits [(k-1)*EW +: EW] of `chrom_in` and `chrom_out`. `src_pos` and `dst_pos` carry 1-based slot numbers.
- R5: When the mutation is active, the output slot `dst_pos` holds the input element from slot `src_pos`.
- R6: When `dst_pos` < `src_pos`, input slots `dst_pos`..`src_pos`-1 appear one slot to the right in the output. Slots outside `dst_pos`..`src_pos` are unchanged. With src 6 and dst 3, {1,7,3,2,0,4,6,5} becomes {1,7,4,3,2,0,6,5}.
- R7: When `dst_pos` > `src_pos`, input slots `src_pos`+1..`dst_pos` appear one slot to the left in the output. Slots outside `src_pos`..`dst_pos` are unchanged.
- R8: When `src_pos` equals `dst_pos`, the output equals the input.
- R9: When `mut_en` is low, the output equals the input.
- R10: When either position is 0 or greater than N, the output equals the input.
- R11: The output always holds the same multiset of element codes as the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request that captures a result |
| mut_en | input | 1 | 1 applies the mutation, 0 passes the chromosome through |
| src_pos | input | PW | 1-based slot of the element to move |
| dst_pos | input | PW | 1-based slot where the element lands |
| chrom_in | input | N*EW | Input chromosome, slot 1 in the low bits |
| chrom_out | output | N*EW | Registered mutated chromosome |
| done | output | 1 | Result valid, one cycle after start |

## Verification
The block is tested with the worked case in which the target lies before the source, and with mirrored cases in which the target lies after it. These cases tell right shifts apart from left shifts. Cases at both ends (slot 1 to slot N and back) and adjacent slots expose off-by-one errors at the window edges. A full sweep of every source/target pair over changing permutations is compared against an independent remove-then-insert model. The pass-through causes (low enable, equal slots, slot 0 and slots past N) are tested separately, so that a wrong range test is told apart from a wrong enable. Input changes without `start` show that the register holds its value.

// File: rtl/pim_pkg.sv
package pim_pkg;

   typedef enum logic [1:0] {
      SHIFT_NONE  = 2'd0,
      SHIFT_RIGHT = 2'd1,
      SHIFT_LEFT  = 2'd2
   } shift_dir_e;

endpackage

// File: rtl/pim_decode.sv
module pim_decode
   import pim_pkg::*;
#(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input  logic          mut_en,
   input  logic [PW-1:0] src_pos,
   input  logic [PW-1:0] dst_pos,
   output shift_dir_e    dir,
   output logic [IW-1:0] src_idx,
   output logic [IW-1:0] lo_idx,
   output logic [IW-1:0] hi_idx
);

   logic          src_ok, dst_ok;
   logic [IW-1:0] dst_idx;

   always_comb begin
      src_ok  = (src_pos != '0) && (src_pos <= PW'(N));
      dst_ok  = (dst_pos != '0) && (dst_pos <= PW'(N));
      src_idx = IW'(src_pos - PW'(1));
      dst_idx = IW'(dst_pos - PW'(1));
      dir     = SHIFT_NONE;
      lo_idx  = '0;
      hi_idx  = '0;
      if (mut_en && src_ok && dst_ok && (src_pos != dst_pos)) begin
         if (dst_pos < src_pos) begin
            dir    = SHIFT_RIGHT;
            lo_idx = dst_idx;
            hi_idx = src_idx;
         end else begin
            dir    = SHIFT_LEFT;
            lo_idx = src_idx;
            hi_idx = dst_idx;
         end
      end
   end

endmodule

// File: rtl/pim_lane.sv
module pim_lane
   import pim_pkg::*;
#(
   parameter int N  = 8,
   parameter int EW = 3,
   parameter int IW = 3,
   parameter int K  = 0
) (
   input  logic [N*EW-1:0] src_vec,
   input  logic [EW-1:0]   moved,
   input  shift_dir_e      dir,
   input  logic [IW-1:0]   lo_idx,
   input  logic [IW-1:0]   hi_idx,
   output logic [EW-1:0]   lane_out
);

   logic [EW-1:0] own_e, prev_e, next_e;

   assign own_e = src_vec[K*EW +: EW];

   generate
      if (K > 0) begin : g_prev
         assign prev_e = src_vec[(K-1)*EW +: EW];
      end else begin : g_no_prev
         assign prev_e = own_e;
      end
      if (K < N-1) begin : g_next
         assign next_e = src_vec[(K+1)*EW +: EW];
      end else begin : g_no_next
         assign next_e = own_e;
      end
   endgenerate

   always_comb begin
      lane_out = own_e;
      unique case (dir)
         SHIFT_RIGHT: begin
            if (int'(lo_idx) == K)
               lane_out = moved;
            else if ((int'(lo_idx) < K) && (K <= int'(hi_idx)))
               lane_out = prev_e;
         end
         SHIFT_LEFT: begin
            if (int'(hi_idx) == K)
               lane_out = moved;
            else if ((int'(lo_idx) <= K) && (K < int'(hi_idx)))
               lane_out = next_e;
         end
         default: lane_out = own_e;
      endcase
   end

endmodule

// File: rtl/perm_shift_mutator.sv
module perm_shift_mutator
   import pim_pkg::*;
#(
   parameter int N  = 8,
   parameter int EW = $clog2(N),
   parameter int PW = $clog2(N+1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            mut_en,
   input  logic [PW-1:0]   src_pos,
   input  logic [PW-1:0]   dst_pos,
   input  logic [N*EW-1:0] chrom_in,
   output logic [N*EW-1:0] chrom_out,
   output logic            done
);

   localparam int IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_n
         $error("perm_shift_mutator: N must be at least 2");
      end
      if (EW < $clog2(N)) begin : g_bad_ew
         $error("perm_shift_mutator: EW too narrow for N codes");
      end
      if (PW < $clog2(N+1)) begin : g_bad_pw
         $error("perm_shift_mutator: PW too narrow for positions 0..N");
      end
   endgenerate

   shift_dir_e      dir;
   logic [IW-1:0]   src_idx, lo_idx, hi_idx;
   logic [EW-1:0]   moved;
   logic [N*EW-1:0] next_vec;

   pim_decode #(.N(N), .PW(PW), .IW(IW)) u_decode (
      .mut_en  (mut_en),
      .src_pos (src_pos),
      .dst_pos (dst_pos),
      .dir     (dir),
      .src_idx (src_idx),
      .lo_idx  (lo_idx),
      .hi_idx  (hi_idx)
   );

   always_comb begin
      moved = chrom_in[int'(src_idx)*EW +: EW];
   end

   generate
      for (genvar k = 0; k < N; k++) begin : g_lane
         pim_lane #(.N(N), .EW(EW), .IW(IW), .K(k)) u_lane (
            .src_vec  (chrom_in),
            .moved    (moved),
            .dir      (dir),
            .lo_idx   (lo_idx),
            .hi_idx   (hi_idx),
            .lane_out (next_vec[k*EW +: EW])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chrom_out <= '0;
         done      <= 1'b0;
      end else begin
         done <= start;
         if (start)
            chrom_out <= next_vec;
      end
   end

endmodule

// File: rtl/pim_check.sv
module pim_check #(
   parameter int N  = 8,
   parameter int EW = 3,
   parameter int PW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            mut_en,
   input logic [PW-1:0]   src_pos,
   input logic [PW-1:0]   dst_pos,
   input logic [N*EW-1:0] chrom_in,
   input logic [N*EW-1:0] chrom_out,
   input logic            done
);

   function automatic logic pos_ok(input logic [PW-1:0] p);
      return (p != '0) && (int'(p) <= N);
   endfunction

   function automatic logic [EW-1:0] slot(input logic [N*EW-1:0] v, input int k1);
      return v[(k1-1)*EW +: EW];
   endfunction

   function automatic logic same_codes(input logic [N*EW-1:0] a, input logic [N*EW-1:0] b);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < N; i++) begin
         int ca, cb;
         ca = 0;
         cb = 0;
         for (int j = 0; j < N; j++) begin
            if (a[j*EW +: EW] == a[i*EW +: EW]) ca++;
            if (b[j*EW +: EW] == a[i*EW +: EW]) cb++;
         end
         if (ca != cb) ok = 1'b0;
      end
      return ok;
   endfunction

   assert_done_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);

   assert_hold_without_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(chrom_out));

   assert_moved_element_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mut_en && pos_ok(src_pos) && pos_ok(dst_pos) && (src_pos != dst_pos))
      |=> slot(chrom_out, int'($past(dst_pos))) == slot($past(chrom_in), int'($past(src_pos))));

   assert_equal_pos_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (src_pos == dst_pos)) |=> chrom_out == $past(chrom_in));

   assert_disabled_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !mut_en) |=> chrom_out == $past(chrom_in));

   assert_range_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !(pos_ok(src_pos) && pos_ok(dst_pos))) |=> chrom_out == $past(chrom_in));

   assert_codes_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> same_codes($past(chrom_in), chrom_out));

endmodule

bind perm_shift_mutator pim_check #(.N(N), .EW(EW), .PW(PW)) u_pim_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mut_en    (mut_en),
   .src_pos   (src_pos),
   .dst_pos   (dst_pos),
   .chrom_in  (chrom_in),
   .chrom_out (chrom_out),
   .done      (done)
);

// File: tb/test_perm_shift_mutator.sv
module test_perm_shift_mutator;

   localparam int N  = 8;
   localparam int EW = 3;
   localparam int PW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            mut_en = 1'b0;
   logic [PW-1:0]   src_pos = '0;
   logic [PW-1:0]   dst_pos = '0;
   logic [N*EW-1:0] chrom_in = '0;
   logic [N*EW-1:0] chrom_out;
   logic            done;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   perm_shift_mutator #(.N(N), .EW(EW), .PW(PW)) i_perm_shift_mutator (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mut_en    (mut_en),
      .src_pos   (src_pos),
      .dst_pos   (dst_pos),
      .chrom_in  (chrom_in),
      .chrom_out (chrom_out),
      .done      (done)
   );

   // slot 1 is the first argument and lands in the low bits (R4)
   function automatic logic [N*EW-1:0] mk(input int e1, e2, e3, e4, e5, e6, e7, e8);
      return {EW'(e8), EW'(e7), EW'(e6), EW'(e5), EW'(e4), EW'(e3), EW'(e2), EW'(e1)};
   endfunction

   // remove-then-insert reference model
   function automatic logic [N*EW-1:0] ref_model(input logic [N*EW-1:0] v, input int s,
                                                 input int d, input logic en);
      int a[N];
      int keep;
      logic [N*EW-1:0] r;
      for (int k = 0; k < N; k++) a[k] = int'(v[k*EW +: EW]);
      if (en && s >= 1 && s <= N && d >= 1 && d <= N) begin
         keep = a[s-1];
         for (int k = s-1; k < N-1; k++) a[k] = a[k+1];
         for (int k = N-1; k > d-1; k--) a[k] = a[k-1];
         a[d-1] = keep;
      end
      for (int k = 0; k < N; k++) r[k*EW +: EW] = EW'(a[k]);
      return r;
   endfunction

   function automatic bit code_match(input logic [N*EW-1:0] a, input logic [N*EW-1:0] b);
      int h[N];
      for (int k = 0; k < N; k++) h[k] = 0;
      for (int k = 0; k < N; k++) begin
         h[a[k*EW +: EW]]++;
         h[b[k*EW +: EW]]--;
      end
      for (int k = 0; k < N; k++) if (h[k] != 0) return 0;
      return 1;
   endfunction

   task automatic check_vec(input string req, input logic [N*EW-1:0] act, input logic [N*EW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: chrom_out=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_bit(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got=%b expected=%b", req, act, exp);
      end
   endtask

   // one mutation request; checks result, done timing and code preservation
   task automatic run_case(input string req, input logic [N*EW-1:0] c, input int s, input int d,
                           input logic en);
      logic [N*EW-1:0] exp;
      exp = ref_model(c, s, d, en);
      @(negedge clk);
      chrom_in = c;
      src_pos  = PW'(s);
      dst_pos  = PW'(d);
      mut_en   = en;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_bit({req, "/R2 done"}, done, 1'b1);
      check_vec(req, chrom_out, exp);
      total++;
      if (!code_match(c, chrom_out)) begin
         bad++;
         $display("FAIL R11: chrom_out=%h not a reorder of %h", chrom_out, c);
      end
      @(negedge clk);
      check_bit("R2 done pulse ends", done, 1'b0);
   endtask

   task automatic t_reset;
      check_vec("R1 reset out", chrom_out, '0);
      check_bit("R1 reset done", done, 1'b0);
   endtask

   task automatic t_worked_case;
      logic [N*EW-1:0] c;
      c = mk(1, 7, 3, 2, 0, 4, 6, 5);
      run_case("R6 worked case", c, 6, 3, 1'b1);
      check_vec("R5 R6 literal", chrom_out, mk(1, 7, 4, 3, 2, 0, 6, 5));
   endtask

   task automatic t_left_shift;
      logic [N*EW-1:0] c;
      c = mk(1, 7, 3, 2, 0, 4, 6, 5);
      run_case("R7 left", c, 2, 7, 1'b1);
      check_vec("R5 R7 literal", chrom_out, mk(1, 3, 2, 0, 4, 6, 7, 5));
   endtask

   task automatic t_edges;
      logic [N*EW-1:0] c;
      c = mk(0, 1, 2, 3, 4, 5, 6, 7);
      run_case("R7 first to last", c, 1, 8, 1'b1);
      check_vec("R4 R7 literal", chrom_out, mk(1, 2, 3, 4, 5, 6, 7, 0));
      run_case("R6 last to first", c, 8, 1, 1'b1);
      check_vec("R4 R6 literal", chrom_out, mk(7, 0, 1, 2, 3, 4, 5, 6));
      run_case("R7 adjacent", c, 4, 5, 1'b1);
      run_case("R6 adjacent", c, 5, 4, 1'b1);
   endtask

   task automatic t_pass_through;
      logic [N*EW-1:0] c;
      c = mk(3, 6, 1, 4, 7, 2, 5, 0);
      run_case("R8 equal slots", c, 5, 5, 1'b1);
      check_vec("R8 literal", chrom_out, c);
      run_case("R9 enable low", c, 6, 2, 1'b0);
      check_vec("R9 literal", chrom_out, c);
      run_case("R10 src zero", c, 0, 4, 1'b1);
      check_vec("R10 src zero literal", chrom_out, c);
      run_case("R10 dst past N", c, 3, 9, 1'b1);
      check_vec("R10 dst past N literal", chrom_out, c);
      run_case("R10 src far", c, 15, 2, 1'b1);
      check_vec("R10 src far literal", chrom_out, c);
   endtask

   task automatic t_hold;
      logic [N*EW-1:0] prev;
      run_case("R6 before hold", mk(2, 4, 6, 0, 1, 3, 5, 7), 7, 2, 1'b1);
      prev = chrom_out;
      @(negedge clk);
      chrom_in = mk(7, 6, 5, 4, 3, 2, 1, 0);
      src_pos  = PW'(1);
      dst_pos  = PW'(8);
      mut_en   = 1'b1;
      repeat (3) @(negedge clk);
      check_vec("R3 hold", chrom_out, prev);
      check_bit("R3 R2 no done", done, 1'b0);
   endtask

   task automatic t_sweep;
      for (int sh = 0; sh < 3; sh++) begin
         for (int s = 1; s <= N; s++) begin
            for (int d = 1; d <= N; d++) begin
               logic [N*EW-1:0] c;
               for (int k = 0; k < N; k++) c[k*EW +: EW] = EW'((k * 3 + sh + s) % N);
               run_case((s < d) ? "R7 sweep" : ((s > d) ? "R6 sweep" : "R8 sweep"), c, s, d, 1'b1);
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_worked_case();
      t_left_shift();
      t_edges();
      t_pass_through();
      t_hold();
      t_sweep();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule